// File: doc/BRIEF.md
# Reprogram Request Pulse Detector

This block watches two active-low request pins of a configured programmable device: a shared done/program pin and a reset pin. It turns a qualifying request on those pins into a single one-cycle pulse, and a clear-state controller takes that pulse as its cue to erase the configuration memory and sample the mode lines again. A request qualifies only when a falling edge is followed by a low level that lasts longer than `LOW_CYCLES` system clocks. A glitch or a short dip produces nothing.

The done/program pin is the primary source. When it has been low for more than `STUCK_CYCLES` clocks, it is taken to be tied low permanently. The block then stops using it and accepts the same edge-and-duration pattern on the reset pin. Requests are honoured only while `configured_i` is high. Both pins pass through a two-flop synchronizer before any edge or level is judged. The block takes an asynchronous active-low reset whose release it resynchronizes internally.

Top module: `reprog_detect`

## Requirements
- R1: After reset is released with both pins high, `reprog_req_o` stays low and no pulse appears.
- R2: When the done/program pin falls and stays low for at least `LOW_CYCLES`+1 clocks, `reprog_req_o` is high for one cycle. The pulse appears exactly `LOW_CYCLES`+3 rising edges after the first edge at which the pin is sampled low. Two of those edges are the synchronizer and one is the output register.
- R3: A low interval of at most `LOW_CYCLES` clocks gives no pulse. After the pin returns high, the duration count starts again from zero on the next falling edge.
- R4: Each qualifying low interval gives exactly one pulse, however long the pin stays low afterwards. A new falling edge is needed before another pulse can occur.
- R5: A pin that is already low when reset is released is not a falling edge. It gives no pulse until the pin has been seen high and then falls.
- R6: No pulse is issued while `configured_i` is low. `configured_i` is sampled in the same cycle in which the duration limit is crossed.
- R7: After the done/program pin has been low for more than `STUCK_CYCLES` clocks, a falling edge on the reset pin followed by more than `LOW_CYCLES` low clocks gives one pulse. Its timing is the same as in R2.
- R8: While the done/program pin is not flagged as stuck, activity on the reset pin gives no pulse.
- R9: While the stuck flag is set, a reset-pin low interval of at most `LOW_CYCLES` clocks gives no pulse.
- R10: Once the done/program pin returns high, the stuck flag is cleared and the reset pin is ignored again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| configured_i | input | 1 | High while the device holds a valid configuration |
| prog_pin_n_i | input | 1 | Done/program pin level, active low, asynchronous |
| rst_pin_n_i | input | 1 | Reset pin level, active low, asynchronous |
| reprog_req_o | output | 1 | One-cycle pulse to the clear-state controller |

## Verification
Two things can land in the same clock: the duration qualifier reaching its limit, and `configured_i` falling. The bench drops `configured_i` for exactly the one cycle in which the count crosses `LOW_CYCLES`, and expects no pulse. It then repeats the drop one cycle later, after the output register has already captured the request, and expects the pulse to survive. A scoreboard records the exact cycle at which each pulse is expected. Any pulse that is late, early or unexpected is reported, and so is any expected pulse that never appears.

// File: rtl/reprog_pkg.sv
package reprog_pkg;
  // Stages in each pin synchronizer chain
  localparam int unsigned SYNC_DEPTH = 2;

  // Result of one low-duration qualifier
  typedef struct packed {
    logic level;  // synchronized pin level
    logic fire;   // duration limit crossed this cycle
  } qual_t;
endpackage

// File: rtl/reprog_pin_sync.sv
module reprog_pin_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  // Chains reset to 0, so a pin counts as "seen high" only after release
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb chain_d = {chain_q[STAGES-2:0], d_i[b]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/reprog_low_qual.sv
module reprog_low_qual
  import reprog_pkg::*;
#(
  parameter int unsigned LOW_CYCLES = 300
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  lvl_i,
  output qual_t q_o
);
  localparam int unsigned CW = $clog2(LOW_CYCLES + 1);

  logic          prev_q;
  logic          armed_q, armed_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          fall, fire;

  // prev_q resets low: a level that is low from reset is not an edge
  assign fall = prev_q & ~lvl_i;
  assign fire = armed_q & ~lvl_i & (cnt_q == CW'(LOW_CYCLES));

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (lvl_i) begin
      armed_d = 1'b0;
      cnt_d   = '0;
      cnt_en  = 1'b1;
    end else if (fall) begin
      armed_d = 1'b1;
      cnt_d   = CW'(1);
      cnt_en  = 1'b1;
    end else if (fire) begin
      armed_d = 1'b0;
      cnt_d   = '0;
      cnt_en  = 1'b1;
    end else if (armed_q) begin
      cnt_d   = cnt_q + CW'(1);
      cnt_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      prev_q  <= lvl_i;
      armed_q <= armed_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign q_o.level = lvl_i;
  assign q_o.fire  = fire;
endmodule

// File: rtl/reprog_stuck_mon.sv
module reprog_stuck_mon #(
  parameter int unsigned STUCK_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic stuck_o
);
  localparam int unsigned SW = $clog2(STUCK_CYCLES + 1);

  logic [SW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          stuck_q, stuck_d;
  logic          at_limit;

  assign at_limit = (cnt_q == SW'(STUCK_CYCLES));

  always_comb begin
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    stuck_d = stuck_q;
    if (lvl_i) begin
      cnt_d   = '0;
      cnt_en  = 1'b1;
      stuck_d = 1'b0;
    end else if (at_limit) begin
      stuck_d = 1'b1;
    end else begin
      cnt_d   = cnt_q + SW'(1);
      cnt_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      stuck_q <= 1'b0;
    end else begin
      stuck_q <= stuck_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign stuck_o = stuck_q;
endmodule

// File: rtl/reprog_detect.sv
module reprog_detect
  import reprog_pkg::*;
#(
  parameter int unsigned LOW_CYCLES   = 300,
  parameter int unsigned STUCK_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic configured_i,
  input  logic prog_pin_n_i,
  input  logic rst_pin_n_i,
  output logic reprog_req_o
);
  localparam int unsigned NPINS = 2;
  localparam int unsigned PROG  = 0;
  localparam int unsigned RSTP  = 1;

  // Reset: asserted at once, released through two flops
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [NPINS-1:0] pins_raw, pins_lvl;
  assign pins_raw[PROG] = prog_pin_n_i;
  assign pins_raw[RSTP] = rst_pin_n_i;

  reprog_pin_sync #(.WIDTH(NPINS), .STAGES(SYNC_DEPTH)) u_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .d_i  (pins_raw),
    .q_o  (pins_lvl)
  );

  logic prog_lvl, rst_lvl;
  assign prog_lvl = pins_lvl[PROG];
  assign rst_lvl  = pins_lvl[RSTP];

  qual_t qual [NPINS];
  for (genvar p = 0; p < NPINS; p++) begin : g_qual
    reprog_low_qual #(.LOW_CYCLES(LOW_CYCLES)) u_qual (
      .clk  (clk),
      .rst_n(rst_sync_n),
      .lvl_i(pins_lvl[p]),
      .q_o  (qual[p])
    );
  end

  logic stuck;
  reprog_stuck_mon #(.STUCK_CYCLES(STUCK_CYCLES)) u_stuck (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .lvl_i  (prog_lvl),
    .stuck_o(stuck)
  );

  // Source select and configured gate, then one output register
  logic fire_sel, req_d, req_q;
  always_comb begin
    fire_sel = stuck ? qual[RSTP].fire : qual[PROG].fire;
    req_d    = fire_sel & configured_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) req_q <= 1'b0;
    else             req_q <= req_d;
  end

  assign reprog_req_o = req_q;
endmodule

// File: rtl/reprog_detect_chk.sv
module reprog_detect_chk (
  input logic clk,
  input logic rst_sync_n,
  input logic configured_i,
  input logic prog_lvl,
  input logic rst_lvl,
  input logic stuck,
  input logic reprog_req_o
);
  // R4: a request is never longer than one cycle
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reprog_req_o |=> !reprog_req_o);

  // R6: a request needs configured in the cycle the limit was crossed
  p_configured_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reprog_req_o |-> $past(configured_i));

  // R2/R7/R8: the selected pin was low in the qualifying cycle
  p_source_low_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reprog_req_o |-> ($past(!prog_lvl && !stuck) || $past(!rst_lvl && stuck)));

  // R7: the stuck flag is only ever set while the primary pin is low
  p_stuck_low_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stuck |-> !$past(prog_lvl));

  // R10: the primary pin going high clears the stuck flag
  p_stuck_clear_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(prog_lvl) |=> !stuck);
endmodule

bind reprog_detect reprog_detect_chk u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .configured_i(configured_i),
  .prog_lvl    (prog_lvl),
  .rst_lvl     (rst_lvl),
  .stuck       (stuck),
  .reprog_req_o(reprog_req_o)
);

// File: tb/sim_reprog_detect.sv
`timescale 1ns/1ps
module sim_reprog_detect;
  localparam int L = 8;
  localparam int S = 40;

  logic clk = 1'b0;
  logic rst_n, configured, prog_n, rstp_n;
  logic req;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  int exp_q[$];
  string tag = "R1";

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  reprog_detect #(.LOW_CYCLES(L), .STUCK_CYCLES(S)) u0 (
    .clk(clk), .rst_n(rst_n), .configured_i(configured),
    .prog_pin_n_i(prog_n), .rst_pin_n_i(rstp_n), .reprog_req_o(req)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  endtask

  // Monitor: pop and compare every pulse
  always @(negedge clk) begin
    if (rst_n === 1'b1 && req === 1'b1) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL %s: unexpected pulse at cycle %0d, expected none", tag, cyc);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != cyc) begin
          failures++;
          $display("FAIL %s: pulse at cycle %0d, expected %0d", tag, cyc, e);
        end
      end
    end
  end

  // Watchdog
  always @(posedge clk) if (cyc > 20000) begin
    checks++; failures++;
    $display("FAIL watchdog: cycle %0d, expected end before 20000", cyc);
    summary();
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drained();
    wait_cyc(L + 6);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL %s: %0d pulses missing, expected 0 outstanding", tag, exp_q.size());
      exp_q.delete();
    end
  endtask

  // Low pulse on a pin; expect a request L+3 edges after drive when w > L
  task automatic low_pulse(input bit on_rst, input int w, input bit expect_req);
    @(negedge clk);
    if (on_rst) rstp_n = 1'b0; else prog_n = 1'b0;
    if (expect_req) exp_q.push_back(cyc + L + 3);
    wait_cyc(w);
    if (on_rst) rstp_n = 1'b1; else prog_n = 1'b1;
  endtask

  task automatic do_reset(input logic prog_level);
    @(negedge clk);
    rst_n = 1'b0; prog_n = prog_level; rstp_n = 1'b1; configured = 1'b1;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(6);
  endtask

  initial begin
    rst_n = 1'b0; configured = 1'b1; prog_n = 1'b1; rstp_n = 1'b1;
    do_reset(1'b1);

    tag = "R1";
    wait_cyc(20);
    checks++;
    if (req !== 1'b0) begin
      failures++; $display("FAIL R1: req=%b, expected 0", req);
    end
    drained();

    tag = "R2";   // minimum qualifying and a longer interval
    low_pulse(1'b0, L + 1, 1'b1); drained();
    low_pulse(1'b0, L + 5, 1'b1); drained();

    tag = "R3";   // too short, then restart of the count
    low_pulse(1'b0, L, 1'b0); drained();
    low_pulse(1'b0, 1, 1'b0); drained();
    low_pulse(1'b0, L, 1'b0);
    wait_cyc(3);
    low_pulse(1'b0, L + 1, 1'b1); drained();

    tag = "R4";   // long hold gives one pulse
    low_pulse(1'b0, 3 * L, 1'b1); drained();

    tag = "R5";   // low across reset release is no edge
    do_reset(1'b0);
    wait_cyc(3 * L);
    drained();
    prog_n = 1'b1; wait_cyc(4);
    low_pulse(1'b0, L + 1, 1'b1); drained();

    tag = "R6";   // unconfigured, then drop in the crossing cycle
    configured = 1'b0;
    low_pulse(1'b0, L + 1, 1'b0); drained();
    configured = 1'b1;
    @(negedge clk); prog_n = 1'b0;
    wait_cyc(L + 2); configured = 1'b0;
    wait_cyc(1);     configured = 1'b1;
    wait_cyc(4);     prog_n = 1'b1;
    drained();
    @(negedge clk); prog_n = 1'b0;
    exp_q.push_back(cyc + L + 3);
    wait_cyc(L + 3); configured = 1'b0;
    wait_cyc(1);     configured = 1'b1;
    wait_cyc(4);     prog_n = 1'b1;
    drained();

    tag = "R8";   // reset pin ignored while primary is live
    low_pulse(1'b1, L + 5, 1'b0); drained();

    tag = "R7";   // primary stuck low, reset pin takes over
    @(negedge clk); prog_n = 1'b0;
    exp_q.push_back(cyc + L + 3);
    wait_cyc(S + 10);
    drained();
    low_pulse(1'b1, L + 1, 1'b1); drained();
    low_pulse(1'b1, 2 * L, 1'b1); drained();

    tag = "R9";   // short reset-pin dip while stuck
    low_pulse(1'b1, L, 1'b0); drained();

    tag = "R10";  // primary released: reset pin ignored again
    prog_n = 1'b1; wait_cyc(5);
    low_pulse(1'b1, L + 3, 1'b0); drained();
    low_pulse(1'b0, L + 1, 1'b1); drained();

    summary();
  end
endmodule